// File: doc/BRIEF.md
# RV64 Word Shift-Immediate Unit

This block decodes and executes the three 64-bit-mode word shift-immediate instructions: logical left, logical right and arithmetic right. Each cycle it takes a 32-bit instruction word, a 64-bit source operand and a mode bit that says whether the register width is 64. It shifts the low 32 bits of the source by a 5-bit immediate amount. It then sign-extends the 32-bit result into a 64-bit value.

The block reports whether the word is a valid instruction of this class or an illegal word inside this opcode space. It also gives the destination register index and a write-enable. All outputs are registered and appear one clock after the inputs. Words outside the opcode space raise neither flag, so that other decoders can claim them.

Top module: `wshift_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output becomes zero after that edge.
- R2: When `insn[6:0]` is not 0011011, `out_valid`, `out_illegal` and `out_we` are 0 and `out_result` is 0.
- R3: With opcode 0011011, `insn[14:12]`=001 and `insn[31:25]`=0000000, the result is the low source word shifted left by the amount, with zeros filled in.
- R4: With opcode 0011011, `insn[14:12]`=101 and `insn[31:25]`=0000000, the result is the low source word shifted right, with zeros filled in.
- R5: With opcode 0011011, `insn[14:12]`=101 and `insn[31:25]`=0100000, the result is the low source word shifted right, with copies of its bit 31 filled in.
- R6: The shift amount is `insn[24:20]` and covers 0 to 31. An amount of 0 returns the low source word unchanged before extension.
- R7: `src_val[63:32]` has no effect on any output.
- R8: `out_result[63:32]` always equals 32 copies of `out_result[31]` when `out_valid` is 1.
- R9: With opcode 0011011 and any other pairing of `insn[14:12]` and `insn[31:25]`, the block sets `out_illegal`=1 and clears `out_valid`, `out_we` and `out_result`. `out_valid` and `out_illegal` are never both 1.
- R10: When `wide_mode` is 0, a word with opcode 0011011 gives `out_illegal`=1 and `out_valid`=0, whatever its other fields hold.
- R11: `out_rd` is always `insn[11:7]`. `out_we` is 1 exactly when `out_valid` is 1 and `out_rd` is not 0.
- R12: The outputs for the inputs present before a rising edge appear right after that edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 when the register width is 64 |
| insn | input | 32 | Instruction word |
| src_val | input | 64 | Source register value |
| out_valid | output | 1 | Word is a legal word shift |
| out_illegal | output | 1 | Word is in this opcode space but not legal |
| out_rd | output | 5 | Destination register index |
| out_we | output | 1 | Register write-enable |
| out_result | output | 64 | Sign-extended shift result |

## Verification
Each of the three shift kinds is swept over all 32 amounts. Random sources are used with bit 31 forced both set and clear. This separates zero fill from sign fill and shows that bit 31 of the result drives the upper half. The sweep also separates the kinds at amount 0, where all three must return the same extended word. Sources that share a low word but differ in the upper half must give identical outputs. Destination 0 must clear only the write-enable. Sweeps of bad function and upper-field pairs, foreign opcodes and 32-bit mode separate the illegal flag from a silent pass.

// File: rtl/wshift_pkg.sv
package wshift_pkg;
  localparam int unsigned INSN_W = 32;
  localparam logic [6:0] OPC_WSHIFT = 7'b0011011;
  localparam logic [2:0] F3_LEFT    = 3'b001;
  localparam logic [2:0] F3_RIGHT   = 3'b101;
  localparam logic [6:0] F7_PLAIN   = 7'b0000000;
  localparam logic [6:0] F7_ARITH   = 7'b0100000;

  typedef enum logic [1:0] {
    SK_NONE  = 2'd0,
    SK_LEFT  = 2'd1,
    SK_RIGHT = 2'd2,
    SK_ARITH = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/wshift_decode.sv
module wshift_decode
  import wshift_pkg::*;
#(
  parameter int unsigned AMT_W = 5
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              wide_mode,
  output logic              dec_valid,
  output logic              dec_illegal,
  output shift_kind_e       dec_kind,
  output logic [AMT_W-1:0]  dec_amt,
  output logic [4:0]        dec_rd
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       space_hit;
  logic       unused_rs1;

  assign opc        = insn[6:0];
  assign f3         = insn[14:12];
  assign f7         = insn[31:25];
  assign dec_rd     = insn[11:7];
  assign dec_amt    = insn[20 +: AMT_W];
  assign unused_rs1 = ^insn[19:15];
  assign space_hit  = (opc == OPC_WSHIFT);

  always_comb begin
    dec_kind = SK_NONE;
    if (f3 == F3_LEFT && f7 == F7_PLAIN)
      dec_kind = SK_LEFT;
    else if (f3 == F3_RIGHT && f7 == F7_PLAIN)
      dec_kind = SK_RIGHT;
    else if (f3 == F3_RIGHT && f7 == F7_ARITH)
      dec_kind = SK_ARITH;
  end

  assign dec_valid   = space_hit && wide_mode && (dec_kind != SK_NONE);
  assign dec_illegal = space_hit && !dec_valid;
endmodule

// File: rtl/wshift_core.sv
module wshift_core
  import wshift_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned XLEN   = 64,
  localparam int unsigned AMT_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [AMT_W-1:0]  amt,
  input  shift_kind_e       kind,
  output logic [XLEN-1:0]   ext_out
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    case (kind)
      SK_LEFT:  shifted = word_in << amt;
      SK_RIGHT: shifted = word_in >> amt;
      SK_ARITH: shifted = WORD_W'($signed(word_in) >>> amt);
      default:  shifted = '0;
    endcase
  end

  assign ext_out = {{(XLEN-WORD_W){shifted[WORD_W-1]}}, shifted};
endmodule

// File: rtl/wshift_unit.sv
module wshift_unit
  import wshift_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned AMT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_mode,
  input  logic [31:0]       insn,
  input  logic [XLEN-1:0]   src_val,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [4:0]        out_rd,
  output logic              out_we,
  output logic [XLEN-1:0]   out_result
);
  logic             d_valid, d_illegal;
  shift_kind_e      d_kind;
  logic [AMT_W-1:0] d_amt;
  logic [4:0]       d_rd;
  logic [XLEN-1:0]  d_result;
  logic             unused_hi;

  assign unused_hi = ^src_val[XLEN-1:WORD_W];

  wshift_decode #(.AMT_W(AMT_W)) u_dec (
    .insn(insn), .wide_mode(wide_mode),
    .dec_valid(d_valid), .dec_illegal(d_illegal),
    .dec_kind(d_kind), .dec_amt(d_amt), .dec_rd(d_rd)
  );

  wshift_core #(.WORD_W(WORD_W), .XLEN(XLEN)) u_core (
    .word_in(src_val[WORD_W-1:0]), .amt(d_amt),
    .kind(d_valid ? d_kind : SK_NONE), .ext_out(d_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_rd      <= '0;
      out_we      <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= d_valid;
      out_illegal <= d_illegal;
      out_rd      <= d_rd;
      out_we      <= d_valid && (d_rd != 5'd0);
      out_result  <= d_valid ? d_result : '0;
    end
  end

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (insn[6:0] != OPC_WSHIFT) |=> (!out_valid && !out_illegal && !out_we)); // R2
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_result[XLEN-1:WORD_W] == {(XLEN-WORD_W){out_result[WORD_W-1]}})); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal)); // R9
  AST_NARROW_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && insn[6:0] == OPC_WSHIFT) |=> (out_illegal && !out_valid)); // R10
  AST_WE_GATED: assert property (@(posedge clk) disable iff (rst)
    out_we |-> (out_valid && out_rd != 5'd0)); // R11
  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_rd == $past(insn[11:7]))); // R11
endmodule

// File: tb/tb_wshift_unit.sv
module tb_wshift_unit;
  localparam int CLK_NS = 10;
  localparam logic [6:0] OPC = 7'b0011011;

  logic clk = 1'b0, rst = 1'b1, wide_mode = 1'b1;
  logic [31:0] insn = '0;
  logic [63:0] src_val = '0;
  logic out_valid, out_illegal, out_we;
  logic [4:0] out_rd;
  logic [63:0] out_result;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  wshift_unit dut (.clk(clk), .rst(rst), .wide_mode(wide_mode), .insn(insn),
    .src_val(src_val), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_rd(out_rd), .out_we(out_we), .out_result(out_result));

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] sh,
      input logic [4:0] rs, input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {f7, sh, rs, f3, rd, op};
  endfunction

  // Reference built from the requirement text.
  task automatic expect_of(input logic [31:0] w, input logic [63:0] s, input logic m,
      output logic v, output logic il, output logic we, output logic [63:0] r);
    logic [31:0] lo, q;
    int sh;
    lo = s[31:0]; sh = int'(w[24:20]); v = 0; il = 0; r = '0; q = '0;
    if (w[6:0] == OPC) begin
      if (m && w[14:12] == 3'b001 && w[31:25] == 7'b0) begin v = 1; q = lo << sh; end
      else if (m && w[14:12] == 3'b101 && w[31:25] == 7'b0) begin v = 1; q = lo >> sh; end
      else if (m && w[14:12] == 3'b101 && w[31:25] == 7'b0100000) begin
        v = 1; q = lo;
        for (int k = 0; k < sh; k++) q = {lo[31], q[31:1]};
      end else il = 1;
      if (v) r = {{32{q[31]}}, q};
    end
    we = v && (w[11:7] != 0);
  endtask

  task automatic apply(input string req, input logic [31:0] w, input logic [63:0] s, input logic m);
    logic v, il, we; logic [63:0] r;
    @(negedge clk); insn = w; src_val = s; wide_mode = m;
    expect_of(w, s, m, v, il, we, r);
    @(negedge clk);
    n_chk++;
    if (out_valid !== v || out_illegal !== il || out_we !== we || out_rd !== w[11:7] || out_result !== r) begin
      n_bad++;
      $display("FAIL %s: got v=%b il=%b we=%b rd=%0d res=%h, expected v=%b il=%b we=%b rd=%0d res=%h",
        req, out_valid, out_illegal, out_we, out_rd, out_result, v, il, we, w[11:7], r);
    end
  endtask

  task automatic t_reset; // R1
    rst = 1; insn = mk(7'b0, 5'd3, 5'd1, 3'b001, 5'd4, OPC); src_val = 64'hFFFF;
    @(negedge clk); @(negedge clk);
    n_chk++;
    if (out_valid !== 0 || out_illegal !== 0 || out_we !== 0 || out_rd !== 0 || out_result !== 0) begin
      n_bad++;
      $display("FAIL R1: got v=%b il=%b we=%b rd=%0d res=%h, expected all zero",
        out_valid, out_illegal, out_we, out_rd, out_result);
    end
    @(negedge clk); rst = 0;
  endtask

  task automatic t_sweep(input string req, input logic [6:0] f7, input logic [2:0] f3); // R3 R4 R5 R6 R8 R12
    for (int sh = 0; sh < 32; sh++) begin
      logic [63:0] s;
      s = {$urandom, $urandom};
      s[31] = sh[0];
      apply(req, mk(f7, 5'(sh), 5'd2, f3, 5'(sh % 31 + 1), OPC), s, 1'b1);
    end
  endtask

  task automatic t_upper_ignored; // R7
    for (int i = 0; i < 8; i++) begin
      logic [31:0] lo; lo = $urandom;
      apply("R7", mk(7'b0100000, 5'(i * 4), 5'd1, 3'b101, 5'd9, OPC), {32'h0, lo}, 1'b1);
      apply("R7", mk(7'b0100000, 5'(i * 4), 5'd1, 3'b101, 5'd9, OPC), {32'hFFFFFFFF, lo}, 1'b1);
    end
  endtask

  task automatic t_rd_zero; // R11
    apply("R11", mk(7'b0, 5'd5, 5'd1, 3'b001, 5'd0, OPC), 64'h1234_5678_8000_0001, 1'b1);
    apply("R11", mk(7'b0, 5'd5, 5'd1, 3'b101, 5'd31, OPC), 64'h1234_5678_8000_0001, 1'b1);
  endtask

  task automatic t_bad_fields; // R9
    for (int f3 = 0; f3 < 8; f3++)
      apply("R9", mk(7'b0000001, 5'd1, 5'd1, 3'(f3), 5'd7, OPC), 64'hFFFF_FFFF, 1'b1);
    apply("R9", mk(7'b0100000, 5'd2, 5'd1, 3'b001, 5'd7, OPC), 64'hF0, 1'b1);
    apply("R9", mk(7'b0, 5'd2, 5'd1, 3'b000, 5'd7, OPC), 64'hF0, 1'b1);
  endtask

  task automatic t_foreign; // R2
    apply("R2", mk(7'b0, 5'd2, 5'd1, 3'b001, 5'd7, 7'b0010011), 64'hF0, 1'b1);
    apply("R2", mk(7'b0, 5'd2, 5'd1, 3'b101, 5'd7, 7'b0011010), 64'hF0, 1'b1);
    apply("R2", mk(7'b0100000, 5'd2, 5'd1, 3'b101, 5'd7, 7'b1011011), 64'hF0, 1'b1);
  endtask

  task automatic t_narrow; // R10
    apply("R10", mk(7'b0, 5'd2, 5'd1, 3'b001, 5'd7, OPC), 64'hF0, 1'b0);
    apply("R10", mk(7'b0100000, 5'd2, 5'd1, 3'b101, 5'd7, OPC), 64'hF0, 1'b0);
    apply("R10", mk(7'b0, 5'd2, 5'd1, 3'b101, 5'd7, 7'b0110011), 64'hF0, 1'b0);
  endtask

  initial begin
    void'($urandom(17));
    t_reset();
    t_sweep("R3", 7'b0, 3'b001);
    t_sweep("R4", 7'b0, 3'b101);
    t_sweep("R5", 7'b0100000, 3'b101);
    apply("R6", mk(7'b0100000, 5'd0, 5'd1, 3'b101, 5'd3, OPC), 64'h0_8765_4321, 1'b1);
    apply("R8", mk(7'b0, 5'd0, 5'd1, 3'b001, 5'd3, OPC), 64'hABCD_0000_7FFF_FFFF, 1'b1);
    apply("R8", mk(7'b0, 5'd1, 5'd1, 3'b001, 5'd3, OPC), 64'h0000_0000_4000_0000, 1'b1);
    t_upper_ignored();
    t_rd_zero();
    t_bad_fields();
    t_foreign();
    t_narrow();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule